// File: doc/BRIEF.md
# Overlapped Flit-Stream Pattern Decompressor

This block sits at the ejection side of a network interface. It receives a cache line that was squeezed with a prefix-tagged significance code and arrives as a wormhole packet, one flit per cycle. It returns the sixteen full 32-bit words of the line. Each word carries a 3-bit tag that gives the pattern the word was reduced to and the number of payload bits that remain for it. All sixteen tags travel in the header flit. The packed payload bits follow in the body flits.

The decode takes five register stages. In the first, the tags become lengths. The second and third form each word's starting bit position as a two-level running sum of those lengths. The fourth cuts each word's field out of the collected bit stream, and the fifth expands the fields into words. The first three stages work from the header alone, so they run while the body flits are still arriving. Once the tail is in, only the last two stages remain. A line sent with its uncompressed flag set carries no meaningful tags, and its payload is copied straight through.

One set of tag and offset registers is held per line in flight. When its extraction happens, the line moves into the output stages, which frees the set for the next header in that same cycle.

Top module: `flit_decomp`

## Requirements
- R1: While reset is held and right after it is released, `line_valid` is 0, `flit_ready` is 1 and `line_words` is all zeros.
- R2: A flit with `flit_head` set is a header. Payload bits [3i+2:3i] (payload = `flit_data[63:0]`) hold the tag of word i, for i = 0..15. Bit 48 is the uncompressed flag. Each later flit adds 64 stream bits: stream bit 64k+j is payload bit j of body flit k. The fields are packed from stream bit 0 upward in word order, word 0 first.
- R3: Tag decoding (field width, rebuilt word): 000 gives 0 bits and zero. 001 gives 4 bits, sign-extended. 010 gives 8 bits, sign-extended. 011 gives 16 bits, sign-extended. 100 gives 16 bits placed in the upper half with the lower half zero. 101 gives 0 bits and all ones. 110 gives 16 bits: bits [7:0] sign-extended form the lower half and bits [15:8] sign-extended form the upper half. 111 gives 32 bits, copied as is.
- R4: When the uncompressed flag is set, the header's tag bits have no effect. Word i equals stream bits [32i+31:32i].
- R5: Each line produces exactly one `line_valid` pulse, one cycle long. With the tail accepted at edge T and the header at edge H, the pulse is registered at edge max(T+2, H+5). Lines leave in the order they arrived.
- R6: `line_words` changes only in a cycle where `line_valid` is high. It holds its value until the next pulse.
- R7: `flit_ready` is low only while a line's tail has been accepted and its offsets are not yet complete. For a header that is also the tail, accepted at edge H, `flit_ready` is low after edges H, H+1 and H+2, and high again after H+3.
- R8: At most one flit is taken per cycle. `flit_data[79:64]` and header payload bits above bit 48 have no effect on the result.
- R9: When a line's tail comes three or more edges after its header, `flit_ready` stays high in the cycle after the tail, so the next header can be taken with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_valid | input | 1 | A flit is offered |
| flit_data | input | 80 | Flit; bits [63:0] are payload, bits [79:64] are network overhead |
| flit_head | input | 1 | Offered flit is a line header |
| flit_tail | input | 1 | Offered flit is the last of its line |
| flit_ready | output | 1 | Offered flit is taken at the next edge |
| line_valid | output | 1 | One-cycle strobe for a rebuilt line |
| line_words | output | 512 | Rebuilt words, word i at bits [32i+31:32i] |

## Verification
The checker assumes the sender behaves: a line opens with a header, its body flits never exceed the eight that a full line needs, and `flit_tail` marks the last of them. With that assumption it can pair each accepted tail with one later strobe. The stimulus builds every packet from a tag list and field values it draws itself. It sizes the body flits from the summed field widths, and a header is also the tail when that sum is zero. It holds each flit until `flit_ready` is high, inserts random idle gaps, and fills the overhead bits with noise.

// File: rtl/flitdec_pkg.sv
package flitdec_pkg;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 16;
    localparam int TAG_W      = 3;
    localparam int PAY_W      = 64;
    localparam int FLIT_W     = 80;
    localparam int GROUP      = 4;

    localparam int HALF_W   = WORD_W / 2;
    localparam int STREAM_W = WORD_W * LINE_WORDS;
    localparam int OFF_W    = $clog2(STREAM_W + 1);
    localparam int LEN_W    = $clog2(WORD_W + 1);
    localparam int BEATS    = STREAM_W / PAY_W;
    localparam int BEAT_W   = $clog2(BEATS + 1);
    localparam int NGROUP   = LINE_WORDS / GROUP;
    localparam int TAGS_W   = LINE_WORDS * TAG_W;
    localparam int RAW_BIT  = TAGS_W;

    typedef enum logic [TAG_W-1:0] {
        TAG_ZERO  = 3'b000,
        TAG_NIB   = 3'b001,
        TAG_BYTE  = 3'b010,
        TAG_HALF  = 3'b011,
        TAG_HIPAD = 3'b100,
        TAG_ONES  = 3'b101,
        TAG_TWOB  = 3'b110,
        TAG_RAW   = 3'b111
    } tag_e;
endpackage

// File: rtl/fd_tag_len.sv
module fd_tag_len
    import flitdec_pkg::*;
(
    input  logic [TAG_W-1:0] tag,
    output logic [LEN_W-1:0] len
);
    always_comb begin
        case (tag_e'(tag))
            TAG_NIB:   len = LEN_W'(4);
            TAG_BYTE:  len = LEN_W'(8);
            TAG_HALF,
            TAG_HIPAD,
            TAG_TWOB:  len = LEN_W'(16);
            TAG_RAW:   len = LEN_W'(WORD_W);
            default:   len = '0;
        endcase
    end
endmodule

// File: rtl/fd_word_expand.sv
module fd_word_expand
    import flitdec_pkg::*;
(
    input  logic [TAG_W-1:0]  tag,
    input  logic [WORD_W-1:0] field,
    output logic [WORD_W-1:0] word
);
    always_comb begin
        case (tag_e'(tag))
            TAG_NIB:   word = {{(WORD_W-4){field[3]}}, field[3:0]};
            TAG_BYTE:  word = {{(WORD_W-8){field[7]}}, field[7:0]};
            TAG_HALF:  word = {{(WORD_W-16){field[15]}}, field[15:0]};
            TAG_HIPAD: word = {field[15:0], {(WORD_W-16){1'b0}}};
            TAG_ONES:  word = '1;
            TAG_TWOB:  word = {{(HALF_W-8){field[15]}}, field[15:8],
                               {(HALF_W-8){field[7]}},  field[7:0]};
            TAG_RAW:   word = field;
            default:   word = '0;
        endcase
    end
endmodule

// File: rtl/flit_decomp.sv
module flit_decomp
    import flitdec_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flit_valid,
    input  logic [FLIT_W-1:0]            flit_data,
    input  logic                         flit_head,
    input  logic                         flit_tail,
    output logic                         flit_ready,
    output logic                         line_valid,
    output logic [STREAM_W-1:0]          line_words
);
    typedef struct packed {
        logic [LINE_WORDS-1:0][TAG_W-1:0]  tags;
        logic [1:0]                        stage;
        logic [LINE_WORDS-1:0][LEN_W-1:0]  lens;
        logic [LINE_WORDS-1:0][OFF_W-1:0]  part;
        logic [NGROUP-1:0][OFF_W-1:0]      gsum;
        logic [LINE_WORDS-1:0][OFF_W-1:0]  offs;
        logic [STREAM_W-1:0]               stream;
        logic [BEAT_W-1:0]                 beat;
        logic                              tail_seen;
        logic                              x_valid;
        logic [LINE_WORDS-1:0][TAG_W-1:0]  x_tags;
        logic [LINE_WORDS-1:0][WORD_W-1:0] x_fields;
        logic                              out_valid;
        logic [LINE_WORDS-1:0][WORD_W-1:0] out_words;
    } state_t;

    state_t state_d, state_q;

    logic [LINE_WORDS-1:0][LEN_W-1:0]  lens_c;
    logic [LINE_WORDS-1:0][WORD_W-1:0] words_c;
    logic [PAY_W-1:0]                  payload;
    logic                              accept;
    logic                              fire;
    logic                              unused_bits;

    assign payload     = flit_data[PAY_W-1:0];
    assign unused_bits = ^{flit_data[FLIT_W-1:RAW_BIT+1]};

    // Stage one (tag to length) and stage five (field to word), one per word.
    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        fd_tag_len u_len (
            .tag (state_q.tags[w]),
            .len (lens_c[w])
        );
        fd_word_expand u_exp (
            .tag   (state_q.x_tags[w]),
            .field (state_q.x_fields[w]),
            .word  (words_c[w])
        );
    end

    // Offsets are complete three edges after the header; a pending tail then
    // moves to extraction, freeing the tag/offset set in the same edge.
    assign fire       = state_q.tail_seen && (state_q.stage == 2'd3);
    assign flit_ready = !state_q.tail_seen || fire;
    assign accept     = flit_valid && flit_ready;

    always_comb begin
        logic [OFF_W-1:0] acc;
        logic [OFF_W-1:0] base;

        state_d = state_q;

        if (state_q.stage != 2'd3) begin
            state_d.stage = state_q.stage + 2'd1;
        end

        // Stage one result.
        state_d.lens = lens_c;

        // Stage two: running sum inside each group, plus the group total.
        for (int g = 0; g < NGROUP; g++) begin
            acc = '0;
            for (int k = 0; k < GROUP; k++) begin
                state_d.part[g*GROUP + k] = acc;
                acc = acc + OFF_W'(state_q.lens[g*GROUP + k]);
            end
            state_d.gsum[g] = acc;
        end

        // Stage three: add the totals of all earlier groups.
        base = '0;
        for (int g = 0; g < NGROUP; g++) begin
            for (int k = 0; k < GROUP; k++) begin
                state_d.offs[g*GROUP + k] = base + state_q.part[g*GROUP + k];
            end
            base = base + state_q.gsum[g];
        end

        // Flit intake.
        if (accept) begin
            if (flit_head) begin
                state_d.tags  = flit_data[RAW_BIT] ? {LINE_WORDS{TAG_RAW}}
                                                   : payload[TAGS_W-1:0];
                state_d.stage = 2'd0;
                state_d.beat  = '0;
            end else if (state_q.beat < BEAT_W'(BEATS)) begin
                for (int b = 0; b < BEATS; b++) begin
                    if (state_q.beat == BEAT_W'(b)) begin
                        state_d.stream[b*PAY_W +: PAY_W] = payload;
                    end
                end
                state_d.beat = state_q.beat + BEAT_W'(1);
            end
        end

        state_d.tail_seen = state_q.tail_seen && !fire;
        if (accept && flit_tail) begin
            state_d.tail_seen = 1'b1;
        end

        // Stage four: cut each field from the stream.
        state_d.x_valid = fire;
        if (fire) begin
            state_d.x_tags = state_q.tags;
            for (int w = 0; w < LINE_WORDS; w++) begin
                state_d.x_fields[w] = WORD_W'(state_q.stream >> state_q.offs[w]);
            end
        end

        // Stage five: register the rebuilt words.
        state_d.out_valid = state_q.x_valid;
        if (state_q.x_valid) begin
            state_d.out_words = words_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign line_valid = state_q.out_valid;
    assign line_words = state_q.out_words;
endmodule

// File: rtl/fd_checker.sv
module fd_checker
    import flitdec_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                flit_valid,
    input logic                flit_tail,
    input logic                flit_ready,
    input logic                line_valid,
    input logic [STREAM_W-1:0] line_words
);
    logic [1:0] pending_q;
    logic [2:0] since_tail_q;
    logic       tail_acc;

    assign tail_acc = flit_valid && flit_ready && flit_tail;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q    <= '0;
            since_tail_q <= 3'd7;
        end else begin
            pending_q <= pending_q + {1'b0, tail_acc} - {1'b0, line_valid};
            if (tail_acc) begin
                since_tail_q <= '0;
            end else if (since_tail_q != 3'd7) begin
                since_tail_q <= since_tail_q + 3'd1;
            end
        end
    end

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |=> !line_valid);

    assert_strobe_has_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> pending_q != 2'd0);

    assert_tail_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && pending_q == 2'd1) |-> since_tail_q >= 3'd2);

    assert_pending_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pending_q <= 2'd2);

    assert_stall_reason_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !flit_ready |-> pending_q != 2'd0);

    assert_words_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_words) |-> line_valid);
endmodule

bind flit_decomp fd_checker u_fd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .flit_valid (flit_valid),
    .flit_tail  (flit_tail),
    .flit_ready (flit_ready),
    .line_valid (line_valid),
    .line_words (line_words)
);

// File: tb/tb_flit_decomp.sv
module tb_flit_decomp;
    import flitdec_pkg::*;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                flit_valid = 1'b0;
    logic [FLIT_W-1:0]   flit_data = '0;
    logic                flit_head = 1'b0;
    logic                flit_tail = 1'b0;
    logic                flit_ready;
    logic                line_valid;
    logic [STREAM_W-1:0] line_words;

    flit_decomp dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .flit_valid (flit_valid),
        .flit_data  (flit_data),
        .flit_head  (flit_head),
        .flit_tail  (flit_tail),
        .flit_ready (flit_ready),
        .line_valid (line_valid),
        .line_words (line_words)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    int                  exp_cyc[$];
    logic [STREAM_W-1:0] exp_words[$];
    logic [STREAM_W-1:0] last_words = '0;

    logic [TAG_W-1:0]  ln_tags   [LINE_WORDS];
    logic [WORD_W-1:0] ln_fields [LINE_WORDS];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req,
                         input logic [STREAM_W-1:0] act, input logic [STREAM_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int tag_len(input logic [TAG_W-1:0] t);
        case (t)
            3'd1: return 4;
            3'd2: return 8;
            3'd3, 3'd4, 3'd6: return 16;
            3'd7: return 32;
            default: return 0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] ref_word(input logic [TAG_W-1:0] t,
                                                   input logic [WORD_W-1:0] f);
        logic signed [WORD_W-1:0] s;
        case (t)
            3'd1: begin s = $signed({f[3:0], 28'h0}) >>> 28; return s; end
            3'd2: begin s = $signed({f[7:0], 24'h0}) >>> 24; return s; end
            3'd3: begin s = $signed({f[15:0], 16'h0}) >>> 16; return s; end
            3'd4: return {f[15:0], 16'h0000};
            3'd5: return 32'hFFFF_FFFF;
            3'd6: return {(f[15] ? 8'hFF : 8'h00), f[15:8], (f[7] ? 8'hFF : 8'h00), f[7:0]};
            3'd7: return f;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] rand_field(input logic [TAG_W-1:0] t);
        logic [WORD_W-1:0] r;
        r = $urandom;
        case (t)
            3'd1: return r & 32'hF;
            3'd2: return r & 32'hFF;
            3'd3, 3'd4, 3'd6: return r & 32'hFFFF;
            3'd7: return r;
            default: return 32'h0;
        endcase
    endfunction

    // Offer one flit and hold it until taken; returns the accepting edge.
    task automatic put_flit(input bit head, input bit tail, input logic [PAY_W-1:0] pay,
                            output int acc_edge);
        flit_valid = 1'b1;
        flit_head  = head;
        flit_tail  = tail;
        flit_data  = {16'($urandom), pay};
        while (!flit_ready) @(negedge clk);
        acc_edge = cyc + 1;
        @(negedge clk);
        flit_valid = 1'b0;
        flit_head  = 1'b0;
        flit_tail  = 1'b0;
        flit_data  = {16'($urandom), 64'($urandom)};
    endtask

    // Sends the line held in ln_tags/ln_fields and queues its expectation.
    task automatic send_line(input bit raw, input int gap_max);
        logic [STREAM_W-1:0] stream;
        logic [STREAM_W-1:0] words;
        logic [PAY_W-1:0]    hdr;
        int pos, nb, h_e, t_e, e;
        stream = '0;
        words  = '0;
        pos    = 0;
        for (int i = 0; i < LINE_WORDS; i++) begin
            int len;
            len = raw ? WORD_W : tag_len(ln_tags[i]);
            stream = stream | (STREAM_W'(ln_fields[i]) << pos);
            pos += len;
            words[i*WORD_W +: WORD_W] = raw ? ln_fields[i] : ref_word(ln_tags[i], ln_fields[i]);
        end
        nb = (pos + PAY_W - 1) / PAY_W;
        hdr = {$urandom, $urandom};
        hdr[RAW_BIT] = raw;
        if (!raw) begin
            for (int i = 0; i < LINE_WORDS; i++) hdr[i*TAG_W +: TAG_W] = ln_tags[i];
        end
        put_flit(1'b1, nb == 0, hdr, h_e);
        t_e = h_e;
        for (int k = 0; k < nb; k++) begin
            int gap;
            gap = (gap_max > 0) ? int'($urandom_range(gap_max)) : 0;
            for (int g = 0; g < gap; g++) @(negedge clk);
            put_flit(1'b0, k == nb - 1, stream[k*PAY_W +: PAY_W], t_e);
        end
        e = (t_e + 2 > h_e + 5) ? t_e + 2 : h_e + 5;
        exp_cyc.push_back(e);
        exp_words.push_back(words);
    endtask

    // Output monitor: strobe timing (R5), data (R2 R3 R4), hold (R6).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (line_valid) begin
                if (exp_cyc.size() == 0) begin
                    check(1'b0, "R5 unexpected strobe", STREAM_W'(cyc), '0);
                end else begin
                    int ec;
                    logic [STREAM_W-1:0] ew;
                    ec = exp_cyc.pop_front();
                    ew = exp_words.pop_front();
                    check(cyc == ec, "R5 strobe cycle", STREAM_W'(cyc), STREAM_W'(ec));
                    check(line_words == ew, "R2 R3 R4 line words", line_words, ew);
                    last_words = ew;
                end
            end else begin
                check(line_words == last_words, "R6 words hold", line_words, last_words);
                if (exp_cyc.size() != 0 && cyc > exp_cyc[0]) begin
                    check(1'b0, "R5 missing strobe", STREAM_W'(cyc), STREAM_W'(exp_cyc[0]));
                    void'(exp_cyc.pop_front());
                    void'(exp_words.pop_front());
                end
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_fails++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1: state during reset.
        check(line_valid == 1'b0, "R1 valid in reset", STREAM_W'(line_valid), '0);
        check(flit_ready == 1'b1, "R1 ready in reset", STREAM_W'(flit_ready), STREAM_W'(1));
        rst_n = 1'b1;
        @(negedge clk);
        check(line_valid == 1'b0, "R1 valid after reset", STREAM_W'(line_valid), '0);
        check(flit_ready == 1'b1, "R1 ready after reset", STREAM_W'(flit_ready), STREAM_W'(1));
        check(line_words == '0, "R1 words after reset", line_words, '0);

        // R3: every tag code, twice over, with sign-bit heavy fields.
        for (int i = 0; i < LINE_WORDS; i++) begin
            ln_tags[i]   = TAG_W'(i % 8);
            ln_fields[i] = (i < 8) ? rand_field(TAG_W'(i)) | (32'h8888_8888 & rand_field(TAG_W'(i)))
                                   : rand_field(TAG_W'(i % 8)) & 32'h7777_7777;
        end
        send_line(1'b0, 0);
        repeat (6) @(negedge clk);

        // R7: header-only line (zero and ones words) stalls three cycles.
        for (int i = 0; i < LINE_WORDS; i++) begin
            ln_tags[i]   = (i % 3 == 0) ? 3'd5 : 3'd0;
            ln_fields[i] = '0;
        end
        send_line(1'b0, 0);
        check(flit_ready == 1'b0, "R7 stall 1", STREAM_W'(flit_ready), '0);
        @(negedge clk);
        check(flit_ready == 1'b0, "R7 stall 2", STREAM_W'(flit_ready), '0);
        @(negedge clk);
        check(flit_ready == 1'b0, "R7 stall 3", STREAM_W'(flit_ready), '0);
        @(negedge clk);
        check(flit_ready == 1'b1, "R7 release", STREAM_W'(flit_ready), STREAM_W'(1));
        repeat (6) @(negedge clk);

        // R4: uncompressed flag with random tag bits in the header.
        for (int i = 0; i < LINE_WORDS; i++) ln_fields[i] = $urandom;
        send_line(1'b1, 1);

        // R9: long line followed at once by another; no bubble after tail.
        for (int i = 0; i < LINE_WORDS; i++) begin
            ln_tags[i]   = 3'd7;
            ln_fields[i] = $urandom;
        end
        send_line(1'b0, 0);
        check(flit_ready == 1'b1, "R9 no bubble after tail", STREAM_W'(flit_ready), STREAM_W'(1));
        for (int i = 0; i < LINE_WORDS; i++) begin
            ln_tags[i]   = TAG_W'($urandom_range(7));
            ln_fields[i] = rand_field(ln_tags[i]);
        end
        send_line(1'b0, 0);

        // R2 R5 R8: random lines, random gaps and overhead bits.
        for (int n = 0; n < 300; n++) begin
            bit raw;
            raw = ($urandom_range(9) == 0);
            for (int i = 0; i < LINE_WORDS; i++) begin
                int pick;
                pick = $urandom_range(9);
                ln_tags[i]   = (pick >= 8) ? 3'd0 : TAG_W'(pick);
                ln_fields[i] = raw ? $urandom : rand_field(ln_tags[i]);
            end
            send_line(raw, $urandom_range(2));
            if ($urandom_range(3) == 0) repeat ($urandom_range(4)) @(negedge clk);
        end

        repeat (12) @(negedge clk);
        check(exp_cyc.size() == 0, "R5 all lines delivered", STREAM_W'(exp_cyc.size()), '0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule